// File: doc/BRIEF.md
# Two-Channel Staged DAC Code Register Front End

This block is the digital side of a two-channel digital-to-analog converter. A host writes codes over a parallel bus that uses an active-low chip select, an active-low write strobe and one channel-address bit. Each write goes into a staging register for one channel. Writes alone never change the converter codes.

A separate active-low load input moves both staged values into the held output registers on the same clock edge, so both converter codes change together. If load is held low while a write completes, the written value goes straight through to that channel's output register on that edge. An asynchronous active-low clear zeroes every register. A power-on reset puts the block in the same all-zero state. An active-low power-down input forces both presented codes to zero and raises a flag. It does not disturb any stored value.

All logic runs on one clock. The host's strobe, select, address and load pins are sampled on that clock. The bus width is a parameter, typically 8 or 10 bits, with the highest bit as the MSB.

Top module: `dac_dual_front`

## Requirements
- R1: A staging register is written only on the clock edge at which the sampled write strobe has just gone from low to high while chip select is low. A rising strobe with chip select high writes nothing.
- R2: The address bit picks the staging register: 0 writes channel A, 1 writes channel B. The other channel is left unchanged.
- R3: The data width is the parameter DATA_W (8 and 10 are both supported). All DATA_W bits are stored, and bit DATA_W-1 is the MSB of the code.
- R4: Clear low zeroes every staging and output register at once, without waiting for a clock edge. Clear overrides writes and loads for as long as it is held.
- R5: On each clock edge where load is sampled low, both output registers take their channel's staged value on that same edge.
- R6: When load is low on the edge where a write completes, the written channel's output register takes the new bus value on that same edge.
- R7: While load is high, output registers keep their value, whatever writes occur.
- R8: While power-down is low, both presented codes read zero and the power-down flag is 1. No register is changed by this. The held codes reappear as soon as power-down returns high.
- R9: After reset, both codes read zero and the power-down flag follows the power-down pin.
- R10: After clear is released, both codes stay at zero until a write and a load occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Power-on reset, asynchronous, active low |
| clrN | input | 1 | Clear of all registers, asynchronous, active low |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low; the write completes on its rising edge |
| addrSel | input | 1 | Channel address: 0 selects A, 1 selects B |
| dataIn | input | DATA_W | Parallel code bus, MSB at top |
| loadN | input | 1 | Load of both output registers, active low |
| pdN | input | 1 | Power-down, active low |
| codeA | output | DATA_W | Presented code for channel A |
| codeB | output | DATA_W | Presented code for channel B |
| pdFlag | output | 1 | High while the block is powered down |

## Verification
Several behaviours are checked by assertions on every clock cycle:
- output registers hold while load is high;
- a load copies the staged value;
- a write under load passes through to the output register;
- registers read zero while clear is low and at the edge where clear is released.

Other behaviours can only be shown by the bench's scenarios, which drive both an 8-bit and a 10-bit instance:
- that clear acts between clock edges;
- that the address bit picks the right channel;
- that a strobe with chip select high is ignored;
- that power-down keeps the stored codes, shown by releasing it.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_A = 0;
  localparam int CH_B = 1;

  typedef struct packed {
    logic [NUM_CH-1:0] wrEn;
    logic              load;
  } strobe_t;
endpackage

// File: rtl/dac_front_ctrl.sv
module dac_front_ctrl
  import dac_front_pkg::*;
(
  input  logic    clk,
  input  logic    arstN,
  input  logic    csN,
  input  logic    wrN,
  input  logic    addrSel,
  input  logic    loadN,
  output strobe_t stb
);
  logic wrPrev;
  logic wrRise;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) wrPrev <= 1'b1;
    else        wrPrev <= wrN;
  end

  assign wrRise = ~wrPrev & wrN;

  always_comb begin
    stb.wrEn = '0;
    if (wrRise && !csN) stb.wrEn[addrSel] = 1'b1;
    stb.load = ~loadN;
  end
endmodule

// File: rtl/dac_front_datapath.sv
module dac_front_datapath
  import dac_front_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              arstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] heldCode [NUM_CH]
);
  logic [DATA_W-1:0] stageReg [NUM_CH];
  logic [DATA_W-1:0] outReg   [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge arstN) begin
      if (!arstN) begin
        stageReg[ch] <= '0;
        outReg[ch]   <= '0;
      end else begin
        if (stb.wrEn[ch]) stageReg[ch] <= dataIn;
        if (stb.load)     outReg[ch]   <= stb.wrEn[ch] ? dataIn : stageReg[ch];
      end
    end
    assign heldCode[ch] = outReg[ch];

    a_r7_hold_without_load: assert property (@(posedge clk) disable iff (!arstN)
      !stb.load |=> $stable(outReg[ch]));
    a_r5_load_copies_stage: assert property (@(posedge clk) disable iff (!arstN)
      (stb.load && !stb.wrEn[ch]) |=> outReg[ch] == $past(stageReg[ch]));
    a_r6_write_passes_through: assert property (@(posedge clk) disable iff (!arstN)
      (stb.load && stb.wrEn[ch]) |=> outReg[ch] == $past(dataIn));
    a_r4_clear_zeroes: assert property (@(posedge clk)
      !arstN |-> (outReg[ch] == '0 && stageReg[ch] == '0));
  end
endmodule

// File: rtl/dac_dual_front.sv
module dac_dual_front
  import dac_front_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              loadN,
  input  logic              pdN,
  output logic [DATA_W-1:0] codeA,
  output logic [DATA_W-1:0] codeB,
  output logic              pdFlag
);
  logic              arstN;
  strobe_t           stb;
  logic [DATA_W-1:0] heldCode [NUM_CH];

  assign arstN = rstN & clrN;

  dac_front_ctrl u_ctrl (
    .clk(clk), .arstN(arstN), .csN(csN), .wrN(wrN),
    .addrSel(addrSel), .loadN(loadN), .stb(stb)
  );

  dac_front_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .arstN(arstN), .stb(stb), .dataIn(dataIn), .heldCode(heldCode)
  );

  assign pdFlag = ~pdN;
  assign codeA  = pdN ? heldCode[CH_A] : '0;
  assign codeB  = pdN ? heldCode[CH_B] : '0;

  a_r10_zero_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clrN) |-> (heldCode[CH_A] == '0 && heldCode[CH_B] == '0));
endmodule

// File: tb/tb_dac_dual_front.sv
`timescale 1ns/1ps
module tb_dac_dual_front;
  logic clk = 0;
  logic rstN = 0, clrN = 1, csN = 1, wrN = 1, addrSel = 0, loadN = 1, pdN = 1;
  logic [9:0] bus = '0;
  logic [7:0] codeA8, codeB8;
  logic [9:0] codeA10, codeB10;
  logic pd8, pd10;
  int total = 0, bad = 0;
  logic [9:0] expIn [2];
  logic [9:0] expDac [2];
  logic expPd = 0;

  always #4 clk = ~clk;

  dac_dual_front #(.DATA_W(8)) dut (
    .clk(clk), .rstN(rstN), .clrN(clrN), .csN(csN), .wrN(wrN), .addrSel(addrSel),
    .dataIn(bus[7:0]), .loadN(loadN), .pdN(pdN), .codeA(codeA8), .codeB(codeB8), .pdFlag(pd8));
  dac_dual_front #(.DATA_W(10)) dutW (
    .clk(clk), .rstN(rstN), .clrN(clrN), .csN(csN), .wrN(wrN), .addrSel(addrSel),
    .dataIn(bus), .loadN(loadN), .pdN(pdN), .codeA(codeA10), .codeB(codeB10), .pdFlag(pd10));

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    logic [9:0] ea, eb;
    ea = expPd ? 10'h0 : expDac[0];
    eb = expPd ? 10'h0 : expDac[1];
    check({tag, " A10"}, codeA10, ea);
    check({tag, " B10"}, codeB10, eb);
    check({tag, " A8"}, {2'b0, codeA8}, ea & 10'h0FF);
    check({tag, " B8"}, {2'b0, codeB8}, eb & 10'h0FF);
    check({tag, " pd"}, {8'b0, pd10, pd8}, {8'b0, expPd, expPd});
  endtask

  task automatic doWrite(bit csLow, bit addr, logic [9:0] d, bit withLoad);
    @(negedge clk);
    csN = !csLow; addrSel = addr; bus = d; wrN = 0; loadN = !withLoad;
    @(negedge clk);
    wrN = 1;
    @(negedge clk);
    csN = 1; loadN = 1; bus = $urandom;
    if (csLow) expIn[addr] = d;
    if (withLoad) begin expDac[0] = expIn[0]; expDac[1] = expIn[1]; end
    #1;
  endtask

  task automatic doLoad();
    @(negedge clk); loadN = 0;
    @(negedge clk); loadN = 1;
    expDac[0] = expIn[0]; expDac[1] = expIn[1];
    #1;
  endtask

  task automatic clearAll();
    expIn[0] = 0; expIn[1] = 0; expDac[0] = 0; expDac[1] = 0;
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clearAll();
    repeat (3) @(negedge clk);
    #1 checkAll("R9 in reset");
    rstN = 1;
    @(negedge clk); #1 checkAll("R9 after reset");

    // R2 and R7: write A and B, no load, outputs unchanged
    doWrite(1, 0, 10'h3A5, 0);
    doWrite(1, 1, 10'h15A, 0);
    checkAll("R7 writes without load");
    doLoad();
    checkAll("R5 R2 load both channels");

    // R3: full width and MSB
    doWrite(1, 0, 10'h3FF, 0);
    doWrite(1, 1, 10'h200, 0);
    doLoad();
    checkAll("R3 full width MSB");

    // R1: strobe with chip select high ignored
    doWrite(0, 0, 10'h011, 0);
    doLoad();
    checkAll("R1 cs high ignored");

    // R6: transparent write with load held low
    doWrite(1, 1, 10'h2C3, 1);
    checkAll("R6 write under load");

    // R8: power-down gates and keeps
    @(negedge clk); pdN = 0; expPd = 1; #1;
    checkAll("R8 powered down");
    doWrite(1, 0, 10'h0F0, 0);
    @(negedge clk); pdN = 1; expPd = 0; #1;
    checkAll("R8 released codes reappear");
    doLoad();
    checkAll("R8 staged write during pd");

    // R4: asynchronous clear between edges, priority over load
    @(negedge clk); #1; loadN = 0; #1 clrN = 0; #1;
    clearAll();
    checkAll("R4 async clear");
    @(negedge clk); loadN = 1;
    doWrite(1, 0, 10'h155, 1);
    expIn[0] = 0; expDac[0] = 0; expDac[1] = 0;
    checkAll("R4 clear overrides write");
    @(negedge clk); clrN = 1; #1;
    checkAll("R10 after release");
    doLoad();
    checkAll("R10 still zero after load only");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: doWrite($urandom_range(0, 3) != 0, $urandom_range(0, 1), 10'($urandom), 0);
        1: doWrite(1, $urandom_range(0, 1), 10'($urandom), 1);
        2: doLoad();
        default: begin
          @(negedge clk); pdN = !pdN; expPd = !pdN; #1;
        end
      endcase
      checkAll("R5 R7 R8 random");
    end
    @(negedge clk); pdN = 1; expPd = 0; #1;
    checkAll("R8 final release");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial void'($urandom(32'h5eed));
endmodule